// File: doc/BRIEF.md
# Masked Interrupt Cause Aggregator

This block collects a small set of event inputs into one pending-cause register. It qualifies each pending bit with a per-source enable bit and drives a single combined interrupt request toward a parent interrupt controller. Software reaches the two registers through a simple 32-bit valid/write/address/data port.

The pending-cause register is not write-one-to-clear. Every write stores the written value as it is. A 1 therefore forces an interrupt pending, and a 0 clears it. To clear one source, software must read the register, remove that bit and write the result back. A rising edge on an event input always wins against a software write in the same cycle, so no hardware event is lost during that read-modify-write window.

Read data is registered. It appears on `bus_rdata` at the clock edge that samples the read request and holds until the next read. The interrupt output is also registered.

Top module: `irq_cause_agg`

## Requirements
- R1: While reset is high and after it is released, the pending and enable registers are all zero, `irq_o` is 0 and `bus_rdata` is 0.
- R2: The pending register sits at byte address 0x00 and the enable register at 0x04, and bit i of each belongs to event input i (i = 0..6). A read (`bus_valid`=1, `bus_write`=0) places the register value from before that clock edge on `bus_rdata` at that edge.
- R3: A write to 0x00 loads pending bits 6..0 with exactly `bus_wdata[6:0]`: a 1 sets a bit pending and a 0 clears it.
- R4: A write to 0x04 loads enable bits 6..0 with exactly `bus_wdata[6:0]`. Enable 1 lets a source reach `irq_o` and enable 0 blocks it.
- R5: `irq_o` equals the OR over all sources of (pending AND enable), registered. It changes one clock edge after the register state changes.
- R6: A 0-to-1 change of an event input sets its pending bit at the next clock edge. The bit stays set until software writes 0 to it. An input held high does not set the bit again after software clears it.
- R7: When a rising edge and a software write to 0x00 hit the same pending bit in the same cycle, the bit ends up set.
- R8: Bits 31..7 of both registers read as 0, and writes to those bits are ignored.
- R9: A read of any address other than 0x00 or 0x04 returns 0, and a write there changes no register.
- R10: A source whose enable bit is 0 still records its pending bit, and that bit is visible on a read, while `irq_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | 7 | Event inputs, synchronous to clk |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
Two functions can fall in the same cycle: an event input's rising edge, and a software write to the pending register that clears the same bit. The bench provokes this collision by driving the input edge and a write of zero in one cycle. It then judges the outcome by reading the pending register back and expecting the bit set. Random runs also overlap edges with pending-register writes. Each cycle there, the bench compares `irq_o` and `bus_rdata` with a bench model that applies the rule that a set beats a write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int CAUSE_OFS = 'h00;
  localparam int MASK_OFS  = 'h04;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MASK  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/irq_bus_dec.sv
module irq_bus_dec
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              wr_o,
  output logic              rd_o
);
  localparam logic [ADDR_W-1:0] CAUSE_A = ADDR_W'(CAUSE_OFS);
  localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(MASK_OFS);

  always_comb begin
    if (addr_i == CAUSE_A)     sel_o = SEL_CAUSE;
    else if (addr_i == MASK_A) sel_o = SEL_MASK;
    else                       sel_o = SEL_NONE;
  end

  assign wr_o = valid_i &  write_i;
  assign rd_o = valid_i & ~write_i;
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] set_i,
  output logic [WIDTH-1:0] cause_o
);
  logic [WIDTH-1:0] base;

  // A hardware set is ORed on top of the software value: the event wins.
  always_comb base = wr_en_i ? wdata_i : cause_o;

  always_ff @(posedge clk) begin
    if (rst) cause_o <= '0;
    else     cause_o <= base | set_i;
  end
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  reg_sel_e          sel;
  logic              wr, rd;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] cause_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] rd_val;

  irq_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i (bus_valid),
    .write_i (bus_write),
    .addr_i  (bus_addr),
    .sel_o   (sel),
    .wr_o    (wr),
    .rd_o    (rd)
  );

  irq_edge_det #(.WIDTH(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (evt_in),
    .rise_o (rise)
  );

  irq_cause_reg #(.WIDTH(NUM_SRC)) u_cause (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr && sel == SEL_CAUSE),
    .wdata_i (bus_wdata[NUM_SRC-1:0]),
    .set_i   (rise),
    .cause_o (cause_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                         mask_q <= '0;
    else if (wr && sel == SEL_MASK)  mask_q <= bus_wdata[NUM_SRC-1:0];
  end

  always_comb begin
    unique case (sel)
      SEL_CAUSE: rd_val = cause_q;
      SEL_MASK:  rd_val = mask_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= {{PAD_W{1'b0}}, rd_val};
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(cause_q & mask_q);
  end
endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk #(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_SRC-1:0] evt_in,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] cause_q,
  input logic [NUM_SRC-1:0] mask_q
);
  logic [NUM_SRC-1:0] evt_prev;
  logic [NUM_SRC-1:0] edge_now;

  always_ff @(posedge clk) begin
    if (rst) evt_prev <= '0;
    else     evt_prev <= evt_in;
  end
  assign edge_now = evt_in & ~evt_prev;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cause_q == '0 && mask_q == '0 && !irq_o && bus_rdata == '0));

  // R5
  a_r5_irq_registered: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(|(cause_q & mask_q))));

  // R6 and R7: every rising edge is recorded
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (|edge_now) |=> ((cause_q & $past(edge_now)) == $past(edge_now)));

  // R6: without an edge or a pending write the cause register holds
  a_r6_cause_holds: assert property (@(posedge clk) disable iff (rst)
    (edge_now == '0 && !(bus_valid && bus_write && bus_addr == ADDR_W'(0)))
      |=> $stable(cause_q));

  // R4
  a_r4_mask_load: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr == ADDR_W'(4))
      |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

  // R9: writes elsewhere leave the enable register alone
  a_r9_mask_untouched: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write && bus_addr == ADDR_W'(4)) |=> $stable(mask_q));

  // R8
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

bind irq_cause_agg irq_cause_agg_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .evt_in(evt_in), .irq_o(irq_o), .cause_q(cause_q), .mask_q(mask_q)
);

// File: tb/test_irq_cause_agg.sv
module test_irq_cause_agg;
  localparam int N = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] evt_in = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_cause_agg i_irq_cause_agg (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq_o(irq_o)
  );

  // Bench model, written from the requirements
  logic [N-1:0] m_cause, m_mask, m_prev;
  logic [31:0]  m_rdata;
  logic         m_irq;

  function automatic logic [N-1:0] next_cause(logic [N-1:0] cur, logic wr,
      logic [31:0] wd, logic [N-1:0] lvl, logic [N-1:0] prev);
    logic [N-1:0] v;
    v = wr ? wd[N-1:0] : cur;
    return v | (lvl & ~prev);
  endfunction

  function automatic logic [31:0] read_val(logic [7:0] a, logic [N-1:0] c,
      logic [N-1:0] m);
    if (a == 8'h00) return {25'd0, c};
    if (a == 8'h04) return {25'd0, m};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cause <= '0; m_mask <= '0; m_prev <= '0; m_rdata <= '0; m_irq <= 1'b0;
    end else begin
      m_cause <= next_cause(m_cause, bus_valid && bus_write && bus_addr == 8'h00,
                            bus_wdata, evt_in, m_prev);
      if (bus_valid && bus_write && bus_addr == 8'h04) m_mask <= bus_wdata[N-1:0];
      if (bus_valid && !bus_write) m_rdata <= read_val(bus_addr, m_cause, m_mask);
      m_prev <= evt_in;
      m_irq  <= |(m_cause & m_mask);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'd0, irq_o}, 32'd0);
    check("R1 rdata in reset", bus_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    rd(8'h00, v); check("R1 cause after reset", v, 32'd0);
    rd(8'h04, v); check("R1 mask after reset", v, 32'd0);

    // R3 / R2 / R5
    wr(8'h04, 32'h7F);
    wr(8'h00, 32'h15);
    rd(8'h00, v); check("R3 cause set by write", v, 32'h15);
    check("R5 irq asserted", {31'd0, irq_o}, 32'd1);
    wr(8'h00, 32'h00);
    check("R5 irq still high one edge after clear", {31'd0, irq_o}, 32'd1);
    @(negedge clk);
    check("R5 irq low after clear", {31'd0, irq_o}, 32'd0);
    rd(8'h00, v); check("R3 cause cleared by write", v, 32'd0);

    // R8
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R8 mask upper bits", v, 32'h7F);
    wr(8'h00, 32'hFFFF_FF80);
    rd(8'h00, v); check("R8 cause upper bits", v, 32'h0);

    // R9
    wr(8'h08, 32'h7F);
    rd(8'h08, v); check("R9 unmapped read", v, 32'h0);
    rd(8'h04, v); check("R9 mask unchanged", v, 32'h7F);
    rd(8'h00, v); check("R9 cause unchanged", v, 32'h0);
    rd(8'h01, v); check("R9 misaligned read", v, 32'h0);

    // R10 / R4
    wr(8'h04, 32'h0);
    evt_in = 7'h08; @(negedge clk); evt_in = '0;
    @(negedge clk);
    rd(8'h00, v); check("R10 masked source recorded", v, 32'h08);
    check("R10 irq stays low", {31'd0, irq_o}, 32'd0);
    wr(8'h04, 32'h08);
    @(negedge clk);
    check("R4 unmask raises irq", {31'd0, irq_o}, 32'd1);
    wr(8'h00, 32'h0);

    // R6: held level sets once
    evt_in = 7'h04; @(negedge clk);
    rd(8'h00, v); check("R6 edge sets cause", v, 32'h04);
    wr(8'h00, 32'h0);
    repeat (2) @(negedge clk);
    rd(8'h00, v); check("R6 held level does not re-set", v, 32'h0);
    evt_in = '0; @(negedge clk);
    evt_in = 7'h04; @(negedge clk);
    rd(8'h00, v); check("R6 new edge sets again", v, 32'h04);
    evt_in = '0;

    // R7: collision
    wr(8'h00, 32'h0);
    evt_in = 7'h20;
    wr(8'h00, 32'h0);
    evt_in = '0;
    rd(8'h00, v); check("R7 edge beats clearing write", v, 32'h20);

    // Random phase compared with the model (R2, R5)
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      k = 2'($urandom_range(0, 3));
      bus_valid = ($urandom_range(0, 3) != 0);
      bus_write = $urandom_range(0, 1) == 1;
      bus_addr  = (k == 0) ? 8'h00 : (k == 1) ? 8'h04 : (k == 2) ? 8'h08 : 8'h01;
      bus_wdata = $urandom;
      evt_in    = ($urandom_range(0, 3) == 0) ? N'($urandom) : evt_in;
      @(negedge clk);
      check("R2 random read data", bus_rdata, m_rdata);
      check("R5 random irq", {31'd0, irq_o}, {31'd0, m_irq});
    end
    bus_valid = 1'b0;
    finish_run();
  end
endmodule